// File: doc/BRIEF.md
# Valley-switching cycle timing controller

This block decides, clock by clock, when the power switch of a free-running flyback converter in critical-conduction mode is on and when it is off. It works only from digital comparator flags that analog front-end logic has already produced.

A current-sense trip flag ends each conduction interval. Trips that arrive early in the interval are masked while the turn-on spike settles, and a hard ceiling on conduction length backs up the trip. After the switch opens, a resonant-valley detect flag starts the next conduction interval. Valleys are masked for a short time after turn-off. If no valley is seen, a timeout or a maximum off-time clamp turns the switch on anyway. A minimum switching period sits over all of these: a turn-on request that comes too early is held and released at the end of that period.

An enable input from the protection logic stops switching at once. When enable returns, a fresh conduction interval starts. Each turn-on is marked by a one-cycle pulse, which other logic can use to count switching cycles. Every duration is a parameter given in clock cycles. A parameter selects whether the valley input is taken as a level or as a rising edge.

Top module: `qr_gate_sequencer`

## Requirements
- R1: While reset is asserted, `gate_o` and `on_pulse_o` are 0. If `enable_i` is 1, the first rising clock edge after reset release starts an on-time, so `gate_o` and `on_pulse_o` are 1 in the following cycle.
- R2: A trip sampled in on-cycle k (on-cycle 0 is the first cycle with `gate_o`=1) ends the on-time after k+1 cycles when k ≥ LEB_CYC. Trips sampled in on-cycles 0 to LEB_CYC-1 are ignored, so a trip held from the start gives an on-time of LEB_CYC+1 cycles.
- R3: `gate_o` is never 1 for more than MAX_ON_CYC consecutive cycles. With no trip, the on-time is exactly MAX_ON_CYC cycles.
- R4: A valley sampled in off-cycle j (off-cycle 0 is the first cycle with `gate_o`=0) is ignored when j < OFF_BLANK_CYC. When j ≥ OFF_BLANK_CYC, it requests a turn-on after j+1 low cycles.
- R5: When DEMAG_TO_CYC is nonzero and no earlier valley request exists, a turn-on is requested after DEMAG_TO_CYC low cycles. DEMAG_TO_CYC = 0 removes this timeout.
- R6: With no other request, a turn-on is requested after MAX_OFF_CYC low cycles.
- R7: Within one enabled run, successive `on_pulse_o` pulses are at least MIN_PERIOD_CYC cycles apart. A request made earlier is latched, and turn-on happens exactly MIN_PERIOD_CYC cycles after the previous turn-on.
- R8: While `enable_i` is 0, `gate_o` is 0 in the same cycle. No pulse is produced, and trips and valleys have no effect.
- R9: The first rising edge with `enable_i`=1 after a cycle with `enable_i`=0 starts a fresh on-time in the next cycle, whatever the minimum period. The on-time has full-length timers.
- R10: `on_pulse_o` is 1 for exactly one cycle, the first cycle of each on-time.
- R11: A trip asserted during the off-time does not change the off-time length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run permission from protection logic |
| cs_trip_i | input | 1 | Current-sense comparator tripped |
| valley_i | input | 1 | Resonant valley detected |
| gate_o | output | 1 | Switch gate command |
| on_pulse_o | output | 1 | One-cycle marker at every turn-on |

## Verification
Every decision is registered, so the response to a trip or valley sampled at a rising edge appears on `gate_o` and `on_pulse_o` in the cycle after that edge. The single exception is the enable mask on `gate_o`, which acts within the same cycle. The bench changes inputs and reads outputs on falling edges. It counts whole cycles of high and low gate, so an on-time ended by a trip sampled in on-cycle k is expected to measure exactly k+1 cycles. Each off-time is expected to end one cycle after the earliest request that is not blanked, held to the minimum-period boundary when that comes later.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2
   } qr_phase_e;

   // Bits needed for a counter running 0 .. span-1.
   function automatic int cnt_width(input int span);
      return (span < 3) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/qr_on_timer.sv
module qr_on_timer #(
   parameter int LEB_CYC    = 4,
   parameter int MAX_ON_CYC = 60
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic active_i,
   input  logic trip_i,
   output logic stop_o
);
   localparam int            W    = qr_gate_pkg::cnt_width(MAX_ON_CYC);
   localparam logic [W-1:0]  LAST = W'(MAX_ON_CYC - 1);

   logic [W-1:0] cnt_q;
   logic         blank_done;

   // Counter is held at zero outside the on phase.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (LEB_CYC == 0) begin : g_no_blank
         assign blank_done = 1'b1;
      end else begin : g_blank
         localparam logic [W-1:0] LEB_V = W'(LEB_CYC);
         assign blank_done = (cnt_q >= LEB_V);
      end
   endgenerate

   assign stop_o = active_i & ((trip_i & blank_done) | (cnt_q == LAST));

endmodule

// File: rtl/qr_off_timer.sv
module qr_off_timer #(
   parameter int OFF_BLANK_CYC = 6,
   parameter int DEMAG_TO_CYC  = 16,
   parameter int MAX_OFF_CYC   = 40
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic active_i,
   input  logic valley_i,
   output logic req_o
);
   localparam int            W    = qr_gate_pkg::cnt_width(MAX_OFF_CYC);
   localparam logic [W-1:0]  LAST = W'(MAX_OFF_CYC - 1);

   logic [W-1:0] cnt_q;
   logic         window_open;
   logic         to_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (OFF_BLANK_CYC == 0) begin : g_no_blank
         assign window_open = 1'b1;
      end else begin : g_blank
         localparam logic [W-1:0] BLANK_V = W'(OFF_BLANK_CYC);
         assign window_open = (cnt_q >= BLANK_V);
      end

      if (DEMAG_TO_CYC > 0) begin : g_timeout
         localparam logic [W-1:0] TO_V = W'(DEMAG_TO_CYC - 1);
         assign to_hit = (cnt_q == TO_V);
      end else begin : g_no_timeout
         assign to_hit = 1'b0;
      end
   endgenerate

   assign req_o = active_i & ((valley_i & window_open) | to_hit | (cnt_q == LAST));

endmodule

// File: rtl/qr_period_guard.sv
module qr_period_guard #(
   parameter int MIN_PERIOD_CYC = 24
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic flush_i,
   input  logic restart_i,
   input  logic req_i,
   output logic fire_o
);
   localparam int            W    = qr_gate_pkg::cnt_width(MIN_PERIOD_CYC);
   localparam logic [W-1:0]  LAST = W'(MIN_PERIOD_CYC - 1);

   logic [W-1:0] per_q;
   logic         held_q;
   logic         period_ok;

   // Cycles since the last turn-on, saturating at the period boundary.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= '0;
      end else if (flush_i || restart_i) begin
         per_q <= '0;
      end else if (per_q != LAST) begin
         per_q <= per_q + 1'b1;
      end
   end

   // An early request is kept until the period allows it.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= 1'b0;
      end else if (flush_i || restart_i) begin
         held_q <= 1'b0;
      end else if (req_i) begin
         held_q <= 1'b1;
      end
   end

   assign period_ok = (per_q == LAST);
   assign fire_o    = (req_i | held_q) & period_ok;

endmodule

// File: rtl/qr_gate_sequencer.sv
module qr_gate_sequencer
   import qr_gate_pkg::*;
#(
   parameter int LEB_CYC        = 4,
   parameter int MAX_ON_CYC     = 60,
   parameter int OFF_BLANK_CYC  = 6,
   parameter int DEMAG_TO_CYC   = 16,
   parameter int MAX_OFF_CYC    = 40,
   parameter int MIN_PERIOD_CYC = 24,
   parameter bit VALLEY_EDGE    = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic cs_trip_i,
   input  logic valley_i,
   output logic gate_o,
   output logic on_pulse_o
);

   initial begin : g_param_chk
      assert (MAX_ON_CYC > LEB_CYC)
         else $error("MAX_ON_CYC must exceed LEB_CYC");
      assert (MAX_OFF_CYC > OFF_BLANK_CYC)
         else $error("MAX_OFF_CYC must exceed OFF_BLANK_CYC");
      assert (DEMAG_TO_CYC == 0 || (DEMAG_TO_CYC > OFF_BLANK_CYC && DEMAG_TO_CYC <= MAX_OFF_CYC))
         else $error("DEMAG_TO_CYC must be 0 or lie between the blank and the off clamp");
      assert (MIN_PERIOD_CYC >= 2)
         else $error("MIN_PERIOD_CYC must be at least 2");
   end

   qr_phase_e phase_q;
   logic      pulse_q;
   logic      valley_evt;
   logic      stop_on;
   logic      off_req;
   logic      fire;
   logic      turn_on;
   logic      turn_off;
   logic      in_on;
   logic      in_off;

   generate
      if (VALLEY_EDGE) begin : g_valley_edge
         logic valley_d;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) valley_d <= 1'b0;
            else         valley_d <= valley_i;
         end
         assign valley_evt = valley_i & ~valley_d;
      end else begin : g_valley_level
         assign valley_evt = valley_i;
      end
   endgenerate

   assign in_on  = (phase_q == PH_ON);
   assign in_off = (phase_q == PH_OFF);

   qr_on_timer #(
      .LEB_CYC    (LEB_CYC),
      .MAX_ON_CYC (MAX_ON_CYC)
   ) u_on (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (in_on),
      .trip_i   (cs_trip_i),
      .stop_o   (stop_on)
   );

   qr_off_timer #(
      .OFF_BLANK_CYC (OFF_BLANK_CYC),
      .DEMAG_TO_CYC  (DEMAG_TO_CYC),
      .MAX_OFF_CYC   (MAX_OFF_CYC)
   ) u_off (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (in_off),
      .valley_i (valley_evt),
      .req_o    (off_req)
   );

   qr_period_guard #(
      .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
   ) u_guard (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (~enable_i),
      .restart_i (turn_on),
      .req_i     (off_req),
      .fire_o    (fire)
   );

   assign turn_on  = enable_i & ((phase_q == PH_IDLE) | (in_off & fire));
   assign turn_off = enable_i & stop_on;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         pulse_q <= 1'b0;
      end else if (!enable_i) begin
         phase_q <= PH_IDLE;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= turn_on;
         if (turn_on) begin
            phase_q <= PH_ON;
         end else if (turn_off) begin
            phase_q <= PH_OFF;
         end
      end
   end

   assign gate_o     = in_on & enable_i;
   assign on_pulse_o = pulse_q & enable_i;

endmodule

// File: rtl/qr_gate_sequencer_chk.sv
module qr_gate_sequencer_chk #(
   parameter int LEB_CYC        = 4,
   parameter int MAX_ON_CYC     = 60,
   parameter int MAX_OFF_CYC    = 40,
   parameter int MIN_PERIOD_CYC = 24
) (
   input logic clk_i,
   input logic rst_ni,
   input logic enable_i,
   input logic gate_o,
   input logic on_pulse_o
);
   localparam int OFF_LIM = (MAX_OFF_CYC > MIN_PERIOD_CYC) ? MAX_OFF_CYC : MIN_PERIOD_CYC;

   int on_len;
   int off_len;
   int gap;
   logic gap_vld;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         on_len  <= 0;
         off_len <= 0;
         gap     <= 0;
         gap_vld <= 1'b0;
      end else begin
         on_len  <= gate_o ? on_len + 1 : 0;
         off_len <= (enable_i && !gate_o) ? off_len + 1 : 0;
         if (!enable_i) begin
            gap_vld <= 1'b0;
         end else if (on_pulse_o) begin
            gap     <= 1;
            gap_vld <= 1'b1;
         end else if (gap < MIN_PERIOD_CYC) begin
            gap <= gap + 1;
         end
      end
   end

   AST_BLANK_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(gate_o) && enable_i) |-> (on_len >= LEB_CYC + 1)); // R2

   AST_ON_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_o |-> (on_len < MAX_ON_CYC)); // R3

   AST_OFF_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && !gate_o) |-> (off_len < OFF_LIM)); // R6

   AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (on_pulse_o && gap_vld) |-> (gap >= MIN_PERIOD_CYC)); // R7

   AST_RESTART_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(enable_i) |=> (on_pulse_o || !enable_i)); // R9

   AST_PULSE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_o) |-> on_pulse_o); // R10

   AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      on_pulse_o |=> !on_pulse_o); // R10

endmodule

bind qr_gate_sequencer qr_gate_sequencer_chk #(
   .LEB_CYC        (LEB_CYC),
   .MAX_ON_CYC     (MAX_ON_CYC),
   .MAX_OFF_CYC    (MAX_OFF_CYC),
   .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .enable_i   (enable_i),
   .gate_o     (gate_o),
   .on_pulse_o (on_pulse_o)
);

// File: tb/qr_gate_sequencer_tb_top.sv
module qr_gate_sequencer_tb_top;

   localparam int LEB    = 4;
   localparam int MAXON  = 60;
   localparam int BLANK  = 6;
   localparam int TOUT   = 16;
   localparam int MAXOFF = 40;
   localparam int MINP   = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b1;
   logic trip = 1'b0;
   logic valley = 1'b0;
   logic trip2 = 1'b1;
   logic valley2 = 1'b0;
   logic gate, pulse, gate2, pulse2;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int on_l, off_l, bad, n;

   always #4 clk = ~clk;

   qr_gate_sequencer #(
      .LEB_CYC(LEB), .MAX_ON_CYC(MAXON), .OFF_BLANK_CYC(BLANK),
      .DEMAG_TO_CYC(TOUT), .MAX_OFF_CYC(MAXOFF), .MIN_PERIOD_CYC(MINP),
      .VALLEY_EDGE(1'b0)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cs_trip_i(trip),
      .valley_i(valley), .gate_o(gate), .on_pulse_o(pulse)
   );

   // Second instance without demag timeout, for the off-time clamp.
   qr_gate_sequencer #(
      .LEB_CYC(LEB), .MAX_ON_CYC(MAXON), .OFF_BLANK_CYC(BLANK),
      .DEMAG_TO_CYC(0), .MAX_OFF_CYC(MAXOFF), .MIN_PERIOD_CYC(MINP),
      .VALLEY_EDGE(1'b0)
   ) dut_nt_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cs_trip_i(trip2),
      .valley_i(valley2), .gate_o(gate2), .on_pulse_o(pulse2)
   );

   // trip_at / valley_at: cycle index of assertion (-1 none); hold: trip kept high while off
   typedef struct packed {
      int trip_at;
      int valley_at;
      int exp_on;
      int exp_off;
      int hold;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{10,  8, 11, 13, 0},  // valley latched by minimum period
      '{20,  8, 21,  9, 0},  // valley after blank
      '{ 0, 10,  5, 19, 0},  // trip inside blank, period hold
      '{20,  3, 21, 16, 0},  // valley in blank ignored, timeout
      '{-1,  7, 60,  8, 0},  // on-time ceiling
      '{30,  6, 31,  7, 0},  // first unblanked off-cycle
      '{30,  5, 31, 16, 0},  // last blanked off-cycle
      '{30, 14, 31, 15, 0},  // valley just before timeout
      '{ 3, -1,  5, 19, 0},  // trip before blank end
      '{ 5,  6,  6, 18, 0},  // trip at blank end, latched valley
      '{20,  8, 21,  9, 1}   // trip held through off-time
   };

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // Entered at a falling edge inside on-cycle 0; returns at the next on-cycle 0.
   task automatic run_cycle(input int t_at, input int v_at, input bit hold,
                            output int on_len, output int off_len);
      int k;
      k = 0;
      on_len = 0;
      off_len = 0;
      while (gate === 1'b1 && on_len < 200) begin
         trip = (t_at >= 0 && k >= t_at);
         if (k == 1) chk(pulse === 1'b0, "R10 pulse lasts one cycle", int'(pulse), 0);
         on_len++;
         k++;
         @(negedge clk);
      end
      trip = hold;
      while (gate === 1'b0 && off_len < 200) begin
         valley = (off_len == v_at);
         off_len++;
         @(negedge clk);
      end
      valley = 1'b0;
      trip = 1'b0;
      chk(pulse === 1'b1, "R10 pulse in first on-cycle", int'(pulse), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(gate === 1'b0, "R1 gate low in reset", int'(gate), 0);
      chk(pulse === 1'b0, "R1 pulse low in reset", int'(pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(gate === 1'b1, "R1 first on-time after reset", int'(gate), 1);
      chk(pulse === 1'b1, "R1 first pulse after reset", int'(pulse), 1);

      for (int i = 0; i < NV; i++) begin
         run_cycle(VEC[i].trip_at, VEC[i].valley_at, VEC[i].hold != 0, on_l, off_l);
         chk(on_l == VEC[i].exp_on,
             $sformatf("R2/R3 on-time vector %0d", i), on_l, VEC[i].exp_on);
         if (VEC[i].hold != 0)
            chk(off_l == VEC[i].exp_off, "R11 off-time with trip held", off_l, VEC[i].exp_off);
         else
            chk(off_l == VEC[i].exp_off,
                $sformatf("R4/R5/R7 off-time vector %0d", i), off_l, VEC[i].exp_off);
      end

      // Disable in the middle of an on-time
      trip = 1'b0;
      repeat (3) @(negedge clk);
      enable = 1'b0;
      #1;
      chk(gate === 1'b0, "R8 gate drops with enable in same cycle", int'(gate), 0);
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gate !== 1'b0 || pulse !== 1'b0) bad++;
         valley = i[0];
         trip = 1'b1;
      end
      chk(bad == 0, "R8 no gate or pulse while disabled", bad, 0);
      valley = 1'b0;
      trip = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      chk(pulse === 1'b1 && gate === 1'b1, "R9 fresh on-time after enable", int'(pulse), 1);
      run_cycle(-1, -1, 1'b0, on_l, off_l);
      chk(on_l == MAXON, "R9 full-length on-time after restart", on_l, MAXON);
      chk(off_l == TOUT, "R5 demag timeout without valley", off_l, TOUT);

      // One-cycle disable right at a turn-on: restart ignores the minimum period
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      chk(pulse === 1'b1, "R9 restart inside minimum period", int'(pulse), 1);

      // Off-time clamp on the instance without timeout
      n = 0;
      while (pulse2 !== 1'b1 && n < 500) begin
         @(negedge clk);
         n++;
      end
      on_l = 0;
      while (gate2 === 1'b1 && on_l < 200) begin
         on_l++;
         @(negedge clk);
      end
      off_l = 0;
      while (gate2 === 1'b0 && off_l < 200) begin
         off_l++;
         @(negedge clk);
      end
      chk(on_l == LEB + 1, "R2 trip held from start of on-time", on_l, LEB + 1);
      chk(off_l == MAXOFF, "R6 maximum off-time clamp", off_l, MAXOFF);
      chk(pulse2 === 1'b1, "R10 pulse at clamp turn-on", int'(pulse2), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule